// File: doc/BRIEF.md
# MPLS label lookup engine

This block makes the label decision for one router in a label-switched network. It keeps a small match table of search keys, each with a valid bit. A hit in that table gives an entry index, and that index is the read address of a separate result memory. A static role input selects how the router behaves:

- **Ingress edge.** The key is a destination IP address, and the result is a label to push.
- **Core.** The key is an incoming label, and the result is the label that replaces it (swap).
- **Egress edge.** The key is an incoming label, the label is popped, and the result is the next-hop IP address.

Lookups come in through a valid/ready request port. A new lookup can be accepted on every clock. Each response arrives at a fixed latency and carries four things: an action code, a result value, the matched index and a miss flag. A write port loads entries and removes them. One write sets an entry's key, result and valid bit together.

Top module: `mlx_label_lookup`

## Requirements
- R1: While `rst` is high, `req_ready` and `rsp_valid` are low. After reset every table entry is invalid, so any lookup misses.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. For a request accepted on edge N, `rsp_valid` is high during the cycle after edge N+1. In every other cycle `rsp_valid` is low. Requests on consecutive cycles produce responses on consecutive cycles, in the same order.
- R3: With role code 00 (ingress), a hit returns action 00 (push) and the stored result, which is the label to add.
- R4: With role code 01 (core), a hit returns action 01 (swap) and the stored outgoing label.
- R5: With role code 10 (egress), a hit returns action 10 (pop) and the stored next-hop IP address.
- R6: When no valid entry holds the key, the response has action 11, `rsp_miss` high, value 0 and index 0. Role code 11 is reserved, and every lookup made under it misses.
- R7: When several valid entries hold the same key, the entry with the lowest index wins.
- R8: A write sets key, result and valid bit of one entry at once. Writing the valid bit as 0 removes the entry from matching. Rewriting an entry changes the result that later lookups return.
- R9: A lookup accepted on the same edge as a write to its entry sees the entry's previous key, result and valid bit. A lookup accepted on the next edge sees the new contents.
- R10: On every response, `rsp_miss` is high exactly when the action is 11. On a hit, `rsp_index` reports the winning entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role | input | 2 | Router role: 00 ingress, 01 core, 10 egress, 11 reserved |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted (high out of reset) |
| req_key | input | KW (32) | Search key: destination IP address or incoming label |
| wr_en | input | 1 | Table write strobe |
| wr_index | input | IW (9) | Entry to write |
| wr_key | input | KW (32) | Key to store |
| wr_result | input | RW (32) | Result to store: label or next-hop IP address |
| wr_entry_valid | input | 1 | Valid bit to store (0 removes the entry) |
| rsp_valid | output | 1 | Response present |
| rsp_action | output | 2 | 00 push, 01 swap, 10 pop, 11 miss |
| rsp_value | output | RW (32) | Result of the winning entry, 0 on a miss |
| rsp_index | output | IW (9) | Index of the winning entry, 0 on a miss |
| rsp_miss | output | 1 | No valid entry matched |

## Verification
The assertions check the response timing on every cycle: `rsp_valid` follows each accepted request by exactly two edges. They also check that the miss flag agrees with the action code, that misses carry zeroed value and index, that hits report the action belonging to the role in force, and that the reserved role never hits. Only the bench scenarios can show what the table holds. That covers which entry wins among duplicates, removal and rewrite of entries, and the old-contents rule when a write and a lookup share an edge. The bench checks each of these against its own reference table.

// File: rtl/mlx_pkg.sv
`timescale 1ns/1ps
package mlx_pkg;
  typedef enum logic [1:0] {
    ROLE_INGRESS = 2'b00,
    ROLE_CORE    = 2'b01,
    ROLE_EGRESS  = 2'b10,
    ROLE_RSVD    = 2'b11
  } role_e;

  typedef enum logic [1:0] {
    ACT_PUSH = 2'b00,
    ACT_SWAP = 2'b01,
    ACT_POP  = 2'b10,
    ACT_MISS = 2'b11
  } action_e;

  function automatic action_e role_action(input logic [1:0] r, input logic hit);
    action_e a;
    if (!hit) a = ACT_MISS;
    else begin
      case (r)
        ROLE_INGRESS: a = ACT_PUSH;
        ROLE_CORE:    a = ACT_SWAP;
        ROLE_EGRESS:  a = ACT_POP;
        default:      a = ACT_MISS;
      endcase
    end
    return a;
  endfunction
endpackage

// File: rtl/mlx_match_table.sv
`timescale 1ns/1ps
module mlx_match_table #(
  parameter int KW    = 32,
  parameter int DEPTH = 512,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_index,
  input  logic [KW-1:0] wr_key,
  input  logic          wr_valid,
  input  logic [KW-1:0] lk_key,
  output logic          lk_hit,
  output logic [IW-1:0] lk_index
);
  logic [KW-1:0]    key_mem [DEPTH];
  logic [DEPTH-1:0] ent_valid;
  logic [DEPTH-1:0] match_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
    end else if (wr_en) begin
      ent_valid[wr_index] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) key_mem[wr_index] <= wr_key;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (key_mem[g] == lk_key);
  end

  // Scan from the top so the lowest matching index is the last to be kept.
  always_comb begin
    lk_hit   = 1'b0;
    lk_index = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        lk_hit   = 1'b1;
        lk_index = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mlx_result_ram.sv
`timescale 1ns/1ps
module mlx_result_ram #(
  parameter int RW    = 32,
  parameter int DEPTH = 512,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic [IW-1:0] rd_addr,
  output logic [RW-1:0] rd_data
);
  logic [RW-1:0] mem [DEPTH];
  logic          stg_en;
  logic [IW-1:0] stg_addr;
  logic [RW-1:0] stg_data;

  // Writes land one edge late, in step with the read stage of the pipeline.
  always_ff @(posedge clk) begin
    if (rst) stg_en <= 1'b0;
    else     stg_en <= wr_en;
    stg_addr <= wr_addr;
    stg_data <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (stg_en) mem[stg_addr] <= stg_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/mlx_label_lookup.sv
`timescale 1ns/1ps
module mlx_label_lookup #(
  parameter int KW    = 32,
  parameter int RW    = 32,
  parameter int DEPTH = 512,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    role,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [KW-1:0] req_key,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_index,
  input  logic [KW-1:0] wr_key,
  input  logic [RW-1:0] wr_result,
  input  logic          wr_entry_valid,
  output logic          rsp_valid,
  output logic [1:0]    rsp_action,
  output logic [RW-1:0] rsp_value,
  output logic [IW-1:0] rsp_index,
  output logic          rsp_miss
);
  import mlx_pkg::*;

  logic          accept;
  logic          mt_hit;
  logic [IW-1:0] mt_index;
  logic          s1_valid, s1_hit;
  logic [IW-1:0] s1_index;
  action_e       s1_action;
  logic          out_hit;
  logic [RW-1:0] ram_q;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  mlx_match_table #(.KW(KW), .DEPTH(DEPTH), .IW(IW)) match_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_index (wr_index),
    .wr_key   (wr_key),
    .wr_valid (wr_entry_valid),
    .lk_key   (req_key),
    .lk_hit   (mt_hit),
    .lk_index (mt_index)
  );

  // Stage 1: register the match outcome.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_hit    <= 1'b0;
      s1_index  <= '0;
      s1_action <= ACT_MISS;
    end else begin
      s1_valid  <= accept;
      s1_hit    <= mt_hit && (role != ROLE_RSVD);
      s1_index  <= mt_index;
      s1_action <= role_action(role, mt_hit);
    end
  end

  mlx_result_ram #(.RW(RW), .DEPTH(DEPTH), .IW(IW)) result_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_index),
    .wr_data (wr_result),
    .rd_addr (s1_index),
    .rd_data (ram_q)
  );

  // Stage 2: result memory read plus response fields.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      out_hit    <= 1'b0;
      rsp_action <= ACT_MISS;
      rsp_index  <= '0;
    end else begin
      rsp_valid  <= s1_valid;
      out_hit    <= s1_hit;
      rsp_action <= s1_hit ? s1_action : ACT_MISS;
      rsp_index  <= s1_hit ? s1_index : '0;
    end
  end

  assign rsp_miss  = !out_hit;
  assign rsp_value = out_hit ? ram_q : '0;
endmodule

// File: rtl/mlx_label_lookup_chk.sv
`timescale 1ns/1ps
module mlx_label_lookup_chk #(
  parameter int RW = 32,
  parameter int IW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    role,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_action,
  input logic [RW-1:0] rsp_value,
  input logic [IW-1:0] rsp_index,
  input logic          rsp_miss
);
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid && req_ready, 2)); // R2

  AST_MISS_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_miss == (rsp_action == 2'b11))); // R10

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |-> (rsp_value == '0 && rsp_index == '0)); // R6

  AST_ROLE_ACTION: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_miss) |-> (rsp_action == $past(role, 2))); // R3

  AST_RSVD_MISS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(role, 2) == 2'b11) |-> rsp_miss); // R6
endmodule

bind mlx_label_lookup mlx_label_lookup_chk #(.RW(RW), .IW(IW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .role       (role),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_action (rsp_action),
  .rsp_value  (rsp_value),
  .rsp_index  (rsp_index),
  .rsp_miss   (rsp_miss)
);

// File: tb/mlx_label_lookup_tb_top.sv
`timescale 1ns/1ps
module mlx_label_lookup_tb_top;
  localparam int KW = 32, RW = 32, DEPTH = 512, IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] role = 2'b00;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [KW-1:0] req_key = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_index = '0;
  logic [KW-1:0] wr_key = '0;
  logic [RW-1:0] wr_result = '0;
  logic wr_entry_valid = 1'b0;
  logic rsp_valid;
  logic [1:0] rsp_action;
  logic [RW-1:0] rsp_value;
  logic [IW-1:0] rsp_index;
  logic rsp_miss;

  int n_checks = 0;
  int n_fail = 0;

  bit [31:0] ref_key [int];
  bit [31:0] ref_res [int];
  bit        ref_vld [int];

  always #2.5 clk = ~clk;

  mlx_label_lookup #(.KW(KW), .RW(RW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .role(role),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
    .wr_en(wr_en), .wr_index(wr_index), .wr_key(wr_key),
    .wr_result(wr_result), .wr_entry_valid(wr_entry_valid),
    .rsp_valid(rsp_valid), .rsp_action(rsp_action), .rsp_value(rsp_value),
    .rsp_index(rsp_index), .rsp_miss(rsp_miss)
  );

  typedef struct packed {
    logic [1:0]    act;
    logic [RW-1:0] val;
    logic [IW-1:0] idx;
    logic          miss;
  } exp_t;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input bit [31:0] key);
    exp_t e;
    e = '{act: 2'b11, val: '0, idx: '0, miss: 1'b1};
    if (role != 2'b11) begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (ref_vld.exists(i) && ref_vld[i] && ref_key[i] == key) begin
          e.act = role; e.val = ref_res[i]; e.idx = IW'(i); e.miss = 1'b0;
        end
      end
    end
    return e;
  endfunction

  task automatic compare(input exp_t e, input string req);
    check(rsp_valid === 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_action === e.act, req, "action", 64'(rsp_action), 64'(e.act));
    check(rsp_value === e.val, req, "value", 64'(rsp_value), 64'(e.val));
    check(rsp_index === e.idx, req, "index", 64'(rsp_index), 64'(e.idx));
    check(rsp_miss === e.miss, "R10", "miss flag", 64'(rsp_miss), 64'(e.miss));
  endtask

  task automatic write_entry(input int idx, input bit [31:0] k, input bit [31:0] r, input bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_index = IW'(idx); wr_key = k; wr_result = r; wr_entry_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    ref_key[idx] = k; ref_res[idx] = r; ref_vld[idx] = v;
  endtask

  task automatic lookup(input bit [31:0] k, input string req);
    exp_t e;
    e = model(k);
    @(negedge clk);
    req_valid = 1'b1; req_key = k;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    compare(e, req);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b0, "R1", "req_ready in reset", 64'(req_ready), 64'd0);
    check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready === 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    role = 2'b00;
    lookup(32'h0A000001, "R1");
  endtask

  task automatic test_ingress();
    role = 2'b00;
    write_entry(5, 32'hC0A80101, 32'h00011000, 1'b1);
    write_entry(9, 32'hC0A80202, 32'h00022000, 1'b1);
    lookup(32'hC0A80101, "R3");
    lookup(32'hC0A80202, "R3");
  endtask

  task automatic test_core();
    role = 2'b01;
    write_entry(20, 32'h00000123, 32'h00000456, 1'b1);
    write_entry(21, 32'h00000777, 32'h00000888, 1'b1);
    lookup(32'h00000123, "R4");
    lookup(32'h00000777, "R4");
  endtask

  task automatic test_egress();
    role = 2'b10;
    write_entry(30, 32'h00000999, 32'h0A0B0C0D, 1'b1);
    lookup(32'h00000999, "R5");
  endtask

  task automatic test_miss();
    role = 2'b01;
    lookup(32'hDEADBEEF, "R6");
    role = 2'b11;
    lookup(32'h00000123, "R6");
    role = 2'b01;
  endtask

  task automatic test_priority();
    role = 2'b01;
    write_entry(40, 32'h00005555, 32'h000000AA, 1'b1);
    write_entry(12, 32'h00005555, 32'h000000BB, 1'b1);
    lookup(32'h00005555, "R7");
    check(rsp_index === IW'(12), "R7", "lowest index wins", 64'(rsp_index), 64'd12);
    write_entry(12, 32'h00005555, 32'h000000BB, 1'b0);
    lookup(32'h00005555, "R8");
    write_entry(40, 32'h00005555, 32'h000000CC, 1'b1);
    lookup(32'h00005555, "R8");
    write_entry(40, 32'h00006666, 32'h000000CC, 1'b1);
    lookup(32'h00005555, "R8");
  endtask

  task automatic test_same_cycle();
    exp_t e_old, e_new;
    role = 2'b00;
    write_entry(60, 32'h0B0B0B0B, 32'h00000101, 1'b1);
    e_old = model(32'h0B0B0B0B);
    @(negedge clk);
    wr_en = 1'b1; wr_index = IW'(60); wr_key = 32'h0B0B0B0B;
    wr_result = 32'h00000202; wr_entry_valid = 1'b1;
    req_valid = 1'b1; req_key = 32'h0B0B0B0B;
    ref_res[60] = 32'h00000202;
    e_new = model(32'h0B0B0B0B);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    compare(e_old, "R9");
    @(negedge clk);
    compare(e_new, "R9");
  endtask

  task automatic test_back_to_back();
    bit [31:0] keys [6];
    exp_t exps [6];
    role = 2'b00;
    keys[0] = 32'hC0A80101; keys[1] = 32'h12345678; keys[2] = 32'hC0A80202;
    keys[3] = 32'h0B0B0B0B; keys[4] = 32'hC0A80101; keys[5] = 32'h00000000;
    for (int i = 0; i < 6; i++) exps[i] = model(keys[i]);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (t >= 2) compare(exps[t-2], "R2");
      if (t < 6) begin req_valid = 1'b1; req_key = keys[t]; end
      else req_valid = 1'b0;
    end
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2", "rsp_valid after burst", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    test_reset();
    test_ingress();
    test_core();
    test_egress();
    test_miss();
    test_priority();
    test_same_cycle();
    test_back_to_back();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule